// File: doc/BRIEF.md
# Serial Result Port for a No-Latency Converter

This block is the digital output side of a converter that reports each result over a three-wire serial link. The three wires are an active-low chip select, a serial clock driven by the host, and a data line that can float. A counter of system clock cycles stands in for the conversion itself. The result word arrives on plain input pins and is captured when that count ends. With chip select high, the block goes to sleep by itself when a conversion finishes and holds the captured result in a shift register.

A host pulls chip select low whenever it wants to know whether a result is ready. While no frame is in progress, the data line shows a busy flag: 1 while a conversion runs and 0 in sleep. Once the host starts clocking, the block sends a 19-bit frame. The first bit is the busy flag, then a constant zero, then a sign bit, then 16 magnitude bits, most significant first. Bits change on falling serial clock edges, and the host samples them on rising edges. The 19th falling edge ends the frame and starts a new conversion.

If chip select rises part-way through a frame, the frame is abandoned and a conversion starts at once. Chip select and the serial clock are resynchronised to the system clock, and their edges are found from the synchronised samples. The enable and the value for the floating data line are separate outputs, so a pad cell outside the block can be driven from them.

Top module: `adc_serial_port`

## Requirements
- R1: `sdo_oe` is 0 whenever the synchronised chip select is high, including during reset, and 1 whenever the synchronised chip select is low.
- R2: While a conversion is running and chip select is low, `sdo_data` is 1.
- R3: A conversion lasts `CONV_CYCLES` system clock cycles. When it ends, the block enters sleep without any host action, and `sdo_data` then reads 0 whenever chip select is low.
- R4: A frame is 19 bits sent in this order: frame bit 1 is the busy flag (0), bit 2 is a constant 0, bit 3 is the captured sign, and bits 4 to 19 are the captured magnitude from bit 15 down to bit 0. Bit k is on `sdo_data` after the (k-1)th falling edge, and it stays there across the kth rising edge.
- R5: The 19th falling serial clock edge of a frame starts a new conversion: `sdo_data` returns to 1, and a fresh result is ready `CONV_CYCLES` cycles later.
- R6: A rising chip select after the first rising serial clock edge and before the 19th falling edge abandons the frame and starts a conversion at once. The next frame carries the new result from bit 1.
- R7: Serial clock edges are ignored, and do not advance the frame, while a conversion runs or while chip select is high.
- R8: After reset, a conversion is running.
- R9: The sign and magnitude are captured only at the end of a conversion. Changing `result_sign` or `result_mag` during a frame does not change the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous active-low chip select from the host |
| sclk_in | input | 1 | Asynchronous serial clock from the host |
| result_sign | input | 1 | Sign of the result, captured at the end of a conversion |
| result_mag | input | DATA_W | Magnitude of the result, captured at the end of a conversion |
| sdo_oe | output | 1 | Enable for the data line pad; 0 means high impedance |
| sdo_data | output | 1 | Value for the data line when it is enabled |

## Verification
The bench checks the frame boundary at both ends: the busy flag as bit 1 and the least significant magnitude bit as bit 19. A design that loaded the frame one bit off would fail there, and so would one that restarted the conversion one edge early. The bench toggles the serial clock while chip select is high in sleep, and again while a conversion runs. A design that let those edges move the shift register would send a truncated frame afterwards. A mid-frame abort is followed by a full frame. This catches a design that stays in sleep after the abort or keeps a stale bit count. The bench also changes the result pins in the middle of a frame, which catches a design that sends the live inputs instead of the captured value.

// File: rtl/adcsp_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial result port.
package adcsp_pkg;

    // Phase of the port: converting, sleeping with a result, or shifting a frame
    typedef enum logic [1:0] {
        PH_CONVERT = 2'd0,
        PH_SLEEP   = 2'd1,
        PH_SHIFT   = 2'd2
    } phase_e;

    // Bits in a frame in front of the magnitude: busy flag, zero, sign
    localparam int HEAD_BITS = 3;

endpackage

// File: rtl/adcsp_sync_edge.sv
`timescale 1ns/1ps
// Resynchronises one asynchronous input to clk and reports its level
// and its single-cycle rise and fall events.
// Assumes the input holds each level for longer than STAGES+1 clk cycles.
module adcsp_sync_edge #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    // Shift the input through the synchroniser and keep one older sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{INIT}};
            prev_q <= INIT;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_async};
            prev_q <= pipe_q[STAGES-1];
        end
    end

    // Level and edge events from the synchronised samples
    always_comb begin
        level = pipe_q[STAGES-1];
        rise  = pipe_q[STAGES-1] & ~prev_q;
        fall  = ~pipe_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/adcsp_conv_timer.sv
`timescale 1ns/1ps
// Stand-in for the conversion: counts CYCLES clk cycles while run is high
// and pulses done in the last one. Dropping run clears the count.
// Assumes CYCLES >= 2.
module adcsp_conv_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count while converting, restart from zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // End of conversion in the final counted cycle
    always_comb begin
        done = run && (cnt_q == LAST);
    end

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/adcsp_frame_shifter.sv
`timescale 1ns/1ps
// Holds the captured result as a frame and sends it most significant bit
// first. A load captures {busy=0, 0, sign, magnitude}. Each shift moves the
// next bit to the output and counts it. last is high while the final bit
// is on the output.
// Assumes load and shift are never high in the same cycle.
module adcsp_frame_shifter
    import adcsp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sign,
    input  logic [DATA_W-1:0] mag,
    input  logic              shift,
    output logic              head_bit,
    output logic              last
);
    localparam int FRAME_W = DATA_W + HEAD_BITS;
    localparam int BCW     = $clog2(FRAME_W);
    localparam logic [BCW-1:0] LAST_IDX = BCW'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg_q;
    logic [BCW-1:0]     bit_q;

    // Capture the frame at the end of a conversion, or advance it one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
        end else if (load) begin
            shreg_q <= {1'b0, 1'b0, sign, mag};
            bit_q   <= '0;
        end else if (shift) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            if (bit_q != LAST_IDX) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Current bit and last-bit flag
    always_comb begin
        head_bit = shreg_q[FRAME_W-1];
        last     = (bit_q == LAST_IDX);
    end

    // R9
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(shreg_q));

    // R4
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= LAST_IDX);

endmodule

// File: rtl/adc_serial_port.sv
`timescale 1ns/1ps
// Serial result port of a no-latency converter.
// Tracks the convert / sleep / shift phase, shows the busy flag while
// chip select is low, and sends a 19-bit frame clocked by the host.
// Assumes the host holds each serial clock level for several clk cycles.
module adc_serial_port
    import adcsp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_in,
    input  logic              sclk_in,
    input  logic              result_sign,
    input  logic [DATA_W-1:0] result_mag,
    output logic              sdo_oe,
    output logic              sdo_data
);
    phase_e phase_q;
    logic   cs_lvl, cs_rise, cs_fall;
    logic   sck_lvl, sck_rise, sck_fall;
    logic   conv_done, shift_en, frame_last, head_bit;

    adcsp_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) cs_sync_i (
        .clk(clk), .rst_n(rst_n), .d_async(cs_n_in),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );

    adcsp_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) sck_sync_i (
        .clk(clk), .rst_n(rst_n), .d_async(sclk_in),
        .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );

    adcsp_conv_timer #(.CYCLES(CONV_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n),
        .run(phase_q == PH_CONVERT),
        .done(conv_done)
    );

    // Only falling edges during a frame with chip select low move the shifter
    always_comb begin
        shift_en = (phase_q == PH_SHIFT) && !cs_lvl && sck_fall;
    end

    adcsp_frame_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk(clk), .rst_n(rst_n),
        .load(conv_done),
        .sign(result_sign), .mag(result_mag),
        .shift(shift_en),
        .head_bit(head_bit), .last(frame_last)
    );

    // Phase sequencing: convert -> sleep -> shift -> convert
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CONVERT;
        end else begin
            unique case (phase_q)
                PH_CONVERT: if (conv_done) phase_q <= PH_SLEEP;
                PH_SLEEP:   if (!cs_lvl && sck_rise) phase_q <= PH_SHIFT;
                PH_SHIFT: begin
                    if (cs_rise)                     phase_q <= PH_CONVERT;
                    else if (shift_en && frame_last) phase_q <= PH_CONVERT;
                end
                default:    phase_q <= PH_CONVERT;
            endcase
        end
    end

    // Pad controls: drive only with chip select low, busy flag while converting
    always_comb begin
        sdo_oe   = !cs_lvl;
        sdo_data = (phase_q == PH_CONVERT) ? 1'b1 : head_bit;
    end

    // R6
    abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHIFT && cs_rise) |=> (phase_q == PH_CONVERT));

    // R5
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && frame_last) |=> (phase_q == PH_CONVERT));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONVERT && !conv_done) |=> (phase_q == PH_CONVERT));

    // R7
    sleep_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SLEEP && cs_lvl) |=> (phase_q == PH_SLEEP));

    // R3
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONVERT && conv_done) |=> (phase_q == PH_SLEEP));

endmodule

// File: tb/adc_serial_port_tb.sv
`timescale 1ns/1ps
module adc_serial_port_tb_top;

    localparam int CONV  = 64;
    localparam int HALF  = 6;
    localparam int NVEC  = 6;
    localparam int FW    = 19;
    localparam logic [16:0] VEC_TAB [NVEC] = '{
        17'h0_0000, 17'h1_FFFF, 17'h0_8001,
        17'h1_5A5A, 17'h0_0F0F, 17'h1_0001
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        r_sign = 1'b0;
    logic [15:0] r_mag = '0;
    logic        sdo_oe, sdo_data;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    adc_serial_port #(.DATA_W(16), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk),
        .result_sign(r_sign), .result_mag(r_mag),
        .sdo_oe(sdo_oe), .sdo_data(sdo_data)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Clocks one frame out and checks each bit at the rising edge (R4)
    task automatic read_frame(input logic [16:0] w, input bit scramble);
        logic [FW-1:0] frame;
        frame = {2'b00, w};
        for (int k = 1; k <= FW; k++) begin
            sclk = 1'b1;
            step(HALF);
            chk($sformatf("R4 frame bit %0d", k), sdo_data, frame[FW-k]);
            if (scramble && k == 2) begin
                r_sign = ~w[16];
                r_mag  = ~w[15:0];
            end
            sclk = 1'b0;
            step(HALF);
        end
        chk("R5 busy after 19th fall", sdo_data, 1'b1);
    endtask

    // Toggles the serial clock n times
    task automatic wiggle(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; step(HALF);
            sclk = 1'b0; step(HALF);
        end
    endtask

    initial begin
        step(3);
        chk("R1 oe low in reset", sdo_oe, 1'b0);
        rst_n = 1'b1;
        cs_n  = 1'b0;
        step(HALF);
        chk("R1 oe high with cs low", sdo_oe, 1'b1);
        chk("R8 converting after reset", sdo_data, 1'b1);
        chk("R2 busy flag", sdo_data, 1'b1);
        cs_n = 1'b1;
        step(HALF);
        chk("R1 oe low with cs high", sdo_oe, 1'b0);

        // Table walk: one full frame per vector
        for (int v = 0; v < NVEC; v++) begin
            r_sign = VEC_TAB[v][16];
            r_mag  = VEC_TAB[v][15:0];
            step(CONV + 10);
            wiggle(3);                       // R7 edges with cs high in sleep
            cs_n = 1'b0;
            step(HALF);
            chk("R3 sleep flag", sdo_data, 1'b0);
            read_frame(VEC_TAB[v], (v % 2) == 1);   // R9 scramble on odd vectors
            cs_n = 1'b1;
            step(HALF);
            chk("R1 oe low after frame", sdo_oe, 1'b0);
        end

        // R7: edges during conversion with cs low are ignored
        r_sign = 1'b1;
        r_mag  = 16'hC3A5;
        step(CONV + 10);
        cs_n = 1'b0;
        step(HALF);
        chk("R3 result ready", sdo_data, 1'b0);
        read_frame(17'h1_C3A5, 1'b0);
        r_sign = 1'b0;
        r_mag  = 16'h7E81;
        wiggle(3);
        chk("R7 still busy after edges", sdo_data, 1'b1);
        step(CONV);
        chk("R5 new result ready", sdo_data, 1'b0);
        read_frame(17'h0_7E81, 1'b0);

        // R6: abort after five rising edges, then a full frame
        step(CONV + 10);
        r_sign = 1'b1;
        r_mag  = 16'h1234;
        chk("R3 sleep before abort", sdo_data, 1'b0);
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; step(HALF);
            if (i < 4) begin sclk = 1'b0; step(HALF); end
        end
        cs_n = 1'b1;
        step(HALF);
        sclk = 1'b0;
        cs_n = 1'b0;
        step(HALF);
        chk("R6 converting after abort", sdo_data, 1'b1);
        step(CONV);
        chk("R6 result after abort", sdo_data, 1'b0);
        read_frame(17'h1_1234, 1'b0);
        cs_n = 1'b1;
        step(HALF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule